// File: doc/BRIEF.md
# Multicycle Instruction Sequencer

This block is the control unit of a multicycle processor whose datapath shares one memory port and one ALU across several clock cycles per instruction. It is a Moore machine. Each state produces a fixed control word, and that word drives every enable and multiplexer select in the datapath: memory address source, memory read and write, instruction register load, program counter load and source, ALU operand selects, ALU mode, and register file write, write-data source and destination select.

Every instruction starts with a fetch cycle and then a decode cycle. The fetch cycle reads the instruction and advances the program counter by four through the ALU. The decode cycle has the ALU form the PC plus the shifted immediate, ahead of any use. At the end of decode the machine samples the 6-bit opcode from the instruction register. There are three outcomes. A register-register opcode runs an execute step and then a register write step. A load opcode runs an address step, a memory read step and a write-back step. Any other opcode goes straight back to fetch.

The block has no data stream, so it has no handshake. All pins are plain control levels, and the datapath is expected to act on them in the same cycle.

Top module: `mc_ctl_fsm`

## Requirements
- R1: A synchronous active-high reset, applied in any state, places the machine in the fetch step on the next clock edge.
- R2: The fetch step drives mem_rd=1, addr_sel_data=0, ir_ld=1, pc_ld=1, pc_src=01, alu_a_sel=0, alu_b_sel=01 and alu_mode=00. Every other output is 0.
- R3: The decode step drives alu_a_sel=0, alu_b_sel=11 and alu_mode=00. Every other output is 0.
- R4: The register-register execute step drives alu_a_sel=1, alu_b_sel=00 and alu_mode=10. Every other output is 0.
- R5: The register-register completion step drives rf_we=1, rf_wdata_sel=0 and rf_dst_sel=1. Every other output is 0.
- R6: The load address step drives alu_a_sel=1, alu_b_sel=10 and alu_mode=00. Every other output is 0.
- R7: The load memory step drives addr_sel_data=1 and mem_rd=1. Every other output is 0.
- R8: The load write-back step drives rf_we=1, rf_wdata_sel=1 and rf_dst_sel=0. Every other output is 0.
- R9: Opcode 000000 gives a 4-cycle sequence (fetch, decode, execute, completion). Opcode 100011 gives a 5-cycle sequence (fetch, decode, address, memory, write-back). Fetch follows either sequence.
- R10: Any other opcode present at the end of decode returns the machine to fetch, for a 2-cycle sequence.
- R11: The opcode is sampled only at the clock edge that ends the decode step. Changes to it in any other step have no effect on the sequence.
- R12: mem_wr stays 0 in every step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field from the instruction register |
| addr_sel_data | output | 1 | Memory address source: 0 = PC, 1 = ALU result register |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| ir_ld | output | 1 | Instruction register load |
| pc_ld | output | 1 | Program counter load |
| pc_src | output | 2 | PC next-value select (01 = ALU output) |
| alu_mode | output | 2 | ALU operation class (00 = add, 10 = function-field) |
| alu_a_sel | output | 1 | ALU A operand: 0 = PC, 1 = register A |
| alu_b_sel | output | 2 | ALU B operand: 00 register B, 01 constant 4, 10 immediate, 11 immediate shifted by 2 |
| rf_we | output | 1 | Register file write enable |
| rf_wdata_sel | output | 1 | Write data: 0 = ALU result register, 1 = memory data register |
| rf_dst_sel | output | 1 | Destination: 0 = second source field, 1 = third register field |

## Verification
The bench targets the branch at the end of decode. A design that keys on the wrong opcode, or that falls into a path for an unknown opcode, produces an execute or address control word where fetch should reappear. The bench also changes the opcode in the middle of a sequence. A machine that samples the opcode outside decode would jump paths, and the write-back step would then show the wrong data source or destination. A reset is applied in the middle of a load to catch a machine that finishes the load before it honours reset. Every step's word is compared bit by bit, so an enable left on in a state that does not list it is caught.

// File: rtl/mcf_pkg.sv
package mcf_pkg;

  typedef enum logic [2:0] {
    ST_FETCH   = 3'd0,
    ST_DECODE  = 3'd1,
    ST_R_EXEC  = 3'd2,
    ST_R_DONE  = 3'd3,
    ST_LD_ADDR = 3'd4,
    ST_LD_MEM  = 3'd5,
    ST_LD_DONE = 3'd6
  } step_t;

  localparam int SEL_W = 2;

  // operand B encodings
  localparam logic [SEL_W-1:0] B_REG     = 2'b00;
  localparam logic [SEL_W-1:0] B_FOUR    = 2'b01;
  localparam logic [SEL_W-1:0] B_IMM     = 2'b10;
  localparam logic [SEL_W-1:0] B_IMM_SHL = 2'b11;

  // ALU class encodings
  localparam logic [SEL_W-1:0] ALU_ADD   = 2'b00;
  localparam logic [SEL_W-1:0] ALU_FUNCT = 2'b10;

  // PC source encodings
  localparam logic [SEL_W-1:0] PCS_ALU   = 2'b01;

  typedef struct packed {
    logic             addr_sel_data;
    logic             mem_rd;
    logic             mem_wr;
    logic             ir_ld;
    logic             pc_ld;
    logic [SEL_W-1:0] pc_src;
    logic [SEL_W-1:0] alu_mode;
    logic             alu_a_sel;
    logic [SEL_W-1:0] alu_b_sel;
    logic             rf_we;
    logic             rf_wdata_sel;
    logic             rf_dst_sel;
  } ctl_word_t;

endpackage

// File: rtl/mcf_next_step.sv
module mcf_next_step
  import mcf_pkg::*;
#(
  parameter int              OPC_W  = 6,
  parameter logic [OPC_W-1:0] R_OPC  = 6'b000000,
  parameter logic [OPC_W-1:0] LD_OPC = 6'b100011
) (
  input  step_t             cur,
  input  logic [OPC_W-1:0]  opcode,
  output step_t             nxt
);

  always_comb begin
    nxt = ST_FETCH;
    unique case (cur)
      ST_FETCH:   nxt = ST_DECODE;
      ST_DECODE: begin
        if (opcode == R_OPC)       nxt = ST_R_EXEC;
        else if (opcode == LD_OPC) nxt = ST_LD_ADDR;
        else                       nxt = ST_FETCH;
      end
      ST_R_EXEC:  nxt = ST_R_DONE;
      ST_R_DONE:  nxt = ST_FETCH;
      ST_LD_ADDR: nxt = ST_LD_MEM;
      ST_LD_MEM:  nxt = ST_LD_DONE;
      ST_LD_DONE: nxt = ST_FETCH;
      default:    nxt = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/mcf_word_decode.sv
module mcf_word_decode
  import mcf_pkg::*;
(
  input  step_t     cur,
  output ctl_word_t word
);

  always_comb begin
    word = '0;
    unique case (cur)
      ST_FETCH: begin
        word.mem_rd    = 1'b1;
        word.ir_ld     = 1'b1;
        word.pc_ld     = 1'b1;
        word.pc_src    = PCS_ALU;
        word.alu_mode  = ALU_ADD;
        word.alu_b_sel = B_FOUR;
      end
      ST_DECODE: begin
        word.alu_mode  = ALU_ADD;
        word.alu_b_sel = B_IMM_SHL;
      end
      ST_R_EXEC: begin
        word.alu_a_sel = 1'b1;
        word.alu_b_sel = B_REG;
        word.alu_mode  = ALU_FUNCT;
      end
      ST_R_DONE: begin
        word.rf_we      = 1'b1;
        word.rf_dst_sel = 1'b1;
      end
      ST_LD_ADDR: begin
        word.alu_a_sel = 1'b1;
        word.alu_b_sel = B_IMM;
        word.alu_mode  = ALU_ADD;
      end
      ST_LD_MEM: begin
        word.addr_sel_data = 1'b1;
        word.mem_rd        = 1'b1;
      end
      ST_LD_DONE: begin
        word.rf_we        = 1'b1;
        word.rf_wdata_sel = 1'b1;
      end
      default: word = '0;
    endcase
  end

endmodule

// File: rtl/mc_ctl_fsm.sv
module mc_ctl_fsm
  import mcf_pkg::*;
#(
  parameter int               OPC_W  = 6,
  parameter logic [OPC_W-1:0] R_OPC  = 6'b000000,
  parameter logic [OPC_W-1:0] LD_OPC = 6'b100011
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  output logic             addr_sel_data,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             ir_ld,
  output logic             pc_ld,
  output logic [1:0]       pc_src,
  output logic [1:0]       alu_mode,
  output logic             alu_a_sel,
  output logic [1:0]       alu_b_sel,
  output logic             rf_we,
  output logic             rf_wdata_sel,
  output logic             rf_dst_sel
);

  step_t     cur_q;
  step_t     nxt;
  ctl_word_t word;

  mcf_next_step #(
    .OPC_W  (OPC_W),
    .R_OPC  (R_OPC),
    .LD_OPC (LD_OPC)
  ) u_next (
    .cur    (cur_q),
    .opcode (opcode),
    .nxt    (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) cur_q <= ST_FETCH;
    else     cur_q <= nxt;
  end

  mcf_word_decode u_word (
    .cur  (cur_q),
    .word (word)
  );

  assign addr_sel_data = word.addr_sel_data;
  assign mem_rd        = word.mem_rd;
  assign mem_wr        = word.mem_wr;
  assign ir_ld         = word.ir_ld;
  assign pc_ld         = word.pc_ld;
  assign pc_src        = word.pc_src;
  assign alu_mode      = word.alu_mode;
  assign alu_a_sel     = word.alu_a_sel;
  assign alu_b_sel     = word.alu_b_sel;
  assign rf_we         = word.rf_we;
  assign rf_wdata_sel  = word.rf_wdata_sel;
  assign rf_dst_sel    = word.rf_dst_sel;

endmodule

// File: rtl/mc_ctl_fsm_chk.sv
module mc_ctl_fsm_chk #(
  parameter int               OPC_W  = 6,
  parameter logic [OPC_W-1:0] R_OPC  = 6'b000000,
  parameter logic [OPC_W-1:0] LD_OPC = 6'b100011
) (
  input logic             clk,
  input logic             rst,
  input logic [OPC_W-1:0] opcode,
  input logic             addr_sel_data,
  input logic             mem_rd,
  input logic             mem_wr,
  input logic             ir_ld,
  input logic             pc_ld,
  input logic [1:0]       pc_src,
  input logic [1:0]       alu_mode,
  input logic             alu_a_sel,
  input logic [1:0]       alu_b_sel,
  input logic             rf_we,
  input logic             rf_wdata_sel,
  input logic             rf_dst_sel
);

  logic in_decode;
  assign in_decode = (alu_b_sel == 2'b11) && !alu_a_sel;

  assert_fetch_to_decode_R3: assert property (@(posedge clk) disable iff (rst)
    ir_ld |=> in_decode && !ir_ld && !pc_ld);

  assert_decode_r_path_R4: assert property (@(posedge clk) disable iff (rst)
    (in_decode && opcode == R_OPC) |=> (alu_mode == 2'b10) && alu_a_sel);

  assert_decode_ld_path_R6: assert property (@(posedge clk) disable iff (rst)
    (in_decode && opcode == LD_OPC) |=> alu_a_sel && (alu_b_sel == 2'b10));

  assert_decode_other_R10: assert property (@(posedge clk) disable iff (rst)
    (in_decode && opcode != R_OPC && opcode != LD_OPC) |=> ir_ld);

  assert_exec_to_done_R5: assert property (@(posedge clk) disable iff (rst)
    (alu_mode == 2'b10) |=> rf_we && rf_dst_sel && !rf_wdata_sel);

  assert_addr_to_mem_R7: assert property (@(posedge clk) disable iff (rst)
    (alu_a_sel && alu_b_sel == 2'b10) |=> addr_sel_data && mem_rd);

  assert_mem_to_wb_R8: assert property (@(posedge clk) disable iff (rst)
    addr_sel_data |=> rf_we && rf_wdata_sel && !rf_dst_sel);

  assert_wb_to_fetch_R9: assert property (@(posedge clk) disable iff (rst)
    rf_we |=> ir_ld && pc_ld && (pc_src == 2'b01));

  assert_no_store_R12: assert property (@(posedge clk) disable iff (rst)
    !mem_wr);

endmodule

bind mc_ctl_fsm mc_ctl_fsm_chk #(
  .OPC_W  (OPC_W),
  .R_OPC  (R_OPC),
  .LD_OPC (LD_OPC)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .opcode        (opcode),
  .addr_sel_data (addr_sel_data),
  .mem_rd        (mem_rd),
  .mem_wr        (mem_wr),
  .ir_ld         (ir_ld),
  .pc_ld         (pc_ld),
  .pc_src        (pc_src),
  .alu_mode      (alu_mode),
  .alu_a_sel     (alu_a_sel),
  .alu_b_sel     (alu_b_sel),
  .rf_we         (rf_we),
  .rf_wdata_sel  (rf_wdata_sel),
  .rf_dst_sel    (rf_dst_sel)
);

// File: tb/tb_mc_ctl_fsm.sv
module tb_mc_ctl_fsm;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'h3f;
  logic       addr_sel_data, mem_rd, mem_wr, ir_ld, pc_ld;
  logic [1:0] pc_src, alu_mode, alu_b_sel;
  logic       alu_a_sel, rf_we, rf_wdata_sel, rf_dst_sel;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  mc_ctl_fsm dut (
    .clk(clk), .rst(rst), .opcode(opcode),
    .addr_sel_data(addr_sel_data), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .ir_ld(ir_ld), .pc_ld(pc_ld), .pc_src(pc_src), .alu_mode(alu_mode),
    .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .rf_we(rf_we),
    .rf_wdata_sel(rf_wdata_sel), .rf_dst_sel(rf_dst_sel)
  );

  // packed order: addr,rd,wr,ir,pc,src[2],alu[2],a,b[2],we,wd,dst
  function automatic logic [14:0] cw(input logic ad, input logic rd, input logic wr,
      input logic ir, input logic pc, input logic [1:0] src, input logic [1:0] alu,
      input logic a, input logic [1:0] b, input logic we, input logic wd, input logic dst);
    return {ad, rd, wr, ir, pc, src, alu, a, b, we, wd, dst};
  endfunction

  logic [14:0] W_FETCH, W_DEC, W_REX, W_RDN, W_LA, W_LM, W_LWB;
  initial begin
    W_FETCH = cw(0,1,0,1,1,2'b01,2'b00,0,2'b01,0,0,0);
    W_DEC   = cw(0,0,0,0,0,2'b00,2'b00,0,2'b11,0,0,0);
    W_REX   = cw(0,0,0,0,0,2'b00,2'b10,1,2'b00,0,0,0);
    W_RDN   = cw(0,0,0,0,0,2'b00,2'b00,0,2'b00,1,0,1);
    W_LA    = cw(0,0,0,0,0,2'b00,2'b00,1,2'b10,0,0,0);
    W_LM    = cw(1,1,0,0,0,2'b00,2'b00,0,2'b00,0,0,0);
    W_LWB   = cw(0,0,0,0,0,2'b00,2'b00,0,2'b00,1,1,0);
  end

  task automatic chk(input string tag, input logic [14:0] exp);
    logic [14:0] got;
    got = {addr_sel_data, mem_rd, mem_wr, ir_ld, pc_ld, pc_src, alu_mode,
           alu_a_sel, alu_b_sel, rf_we, rf_wdata_sel, rf_dst_sel};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
    chk("R1 reset word is fetch", W_FETCH);
  endtask

  task automatic t_rtype();
    opcode = 6'b000000;
    chk("R2 fetch", W_FETCH);                 step();
    chk("R3 decode", W_DEC);                  step();
    chk("R4 r exec", W_REX);                  step();
    chk("R5 r done", W_RDN);                  step();
    chk("R9 r-type back to fetch after 4", W_FETCH);
  endtask

  task automatic t_load();
    opcode = 6'b100011;
    chk("R2 fetch", W_FETCH);                 step();
    chk("R3 decode", W_DEC);                  step();
    chk("R6 ld addr", W_LA);                  step();
    chk("R7 ld mem", W_LM);                   step();
    chk("R8 ld wb", W_LWB);                   step();
    chk("R9 load back to fetch after 5", W_FETCH);
  endtask

  task automatic t_other(input logic [5:0] op);
    opcode = op;
    chk("R10 fetch", W_FETCH);                step();
    chk("R10 decode", W_DEC);                 step();
    chk("R10 unknown opcode back to fetch", W_FETCH);
  endtask

  task automatic t_ignore();
    opcode = 6'b101011;                       // unknown during fetch
    chk("R11 fetch", W_FETCH);                step();
    opcode = 6'b000000;                       // valid at decode edge
    chk("R11 decode", W_DEC);                 step();
    opcode = 6'b100011;                       // changed during execute
    chk("R11 exec unaffected", W_REX);        step();
    opcode = 6'b000100;
    chk("R11 done unaffected", W_RDN);        step();
    chk("R11 fetch after", W_FETCH);
  endtask

  task automatic t_mid_reset();
    opcode = 6'b100011;
    step(); step(); step();
    chk("R1 in ld mem before reset", W_LM);
    rst = 1'b1;
    step();
    rst = 1'b0;
    chk("R1 reset mid-load gives fetch", W_FETCH);
    opcode = 6'b000000;
    step();
    chk("R1 decode after reset", W_DEC);
    step();
    chk("R1 r exec after reset", W_REX);
    step(); step();
  endtask

  initial begin
    #(8 * 20000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_rtype();
    t_load();
    t_other(6'b101011);
    t_other(6'b000010);
    t_rtype();
    t_ignore();
    t_mid_reset();
    t_load();
    if (mem_wr !== 1'b0) begin
      bad++;
      $display("FAIL R12 mem_wr got=%b exp=0", mem_wr);
    end
    total++;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // R12: write enable sampled on every falling edge after reset
  always @(negedge clk) begin
    if (!rst && mem_wr !== 1'b0) begin
      total++;
      bad++;
      $display("FAIL R12 mem_wr got=%b exp=0", mem_wr);
    end
  end

endmodule